// File: doc/BRIEF.md
# Radio Packet Framer with CRC-16

This block turns a payload of up to 255 bytes into a complete over-the-air packet for a byte-oriented radio transmitter. A single start pulse latches the payload length, a group identifier and a header byte. The block then produces the whole frame in order: a run of 0xAA training bytes, the fixed sync byte 0x2D, the group byte, the header, the length, the payload, a 16-bit checksum and a final 0xAA pad byte. The pad byte lets the last real byte leave the radio's shift register before the transmitter is switched off.

Payload bytes come in over a valid/ready handshake and pass straight through to the output. The output side offers one byte at a time with `tx_valid`. A byte counts as sent only in a cycle where the radio's "transmit register ready" flag `tx_ready` is also high. The checksum is a reflected CRC-16 with polynomial 0xA001. It is seeded with 0xFFFF, updated one byte per accepted byte, and it covers only the group, header, length and payload fields.

Top module: `radio_framer`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `tx_valid` and `in_ready` are all 0.
- R2: A start pulse with a non-zero length while idle raises `busy` on the next cycle. The accepted bytes are then, in this order: three 0xAA, 0x2D, the group byte, the header byte, the length byte, and the payload bytes in arrival order.
- R3: A byte advances only in a cycle with `tx_valid` and `tx_ready` both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold their values.
- R4: The checksum starts at 0xFFFF on each frame. For every accepted group, header, length and payload byte, the byte is XORed into the low 8 bits and the value is shifted right eight times, XORing in 0xA001 whenever the bit shifted out is 1. Preamble, sync, checksum and pad bytes do not change it.
- R5: The checksum goes out right after the payload, bits 7:0 first and bits 15:8 second.
- R6: The byte after the checksum is a pad byte of 0xAA.
- R7: A start pulse with length 0 sends nothing. The block stays idle, with `busy`, `tx_valid` and `done` all low.
- R8: `done` is high for exactly one cycle, the cycle after the pad byte is accepted. In that same cycle `busy` is already low.
- R9: A start pulse while `busy` is high is ignored. The frame in progress keeps the length, group and header it started with.
- R10: `in_ready` is high only during the payload phase and only while `tx_ready` is high. In the payload phase `tx_valid` follows `in_valid`, so a missing payload byte stalls the frame without sending anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a new frame |
| frame_len | input | 8 | Payload byte count, latched at start |
| group_id | input | 8 | Group byte, latched at start |
| header_byte | input | 8 | Header byte, latched at start |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte taken this cycle when valid |
| tx_byte | output | 8 | Byte offered to the radio |
| tx_valid | output | 1 | `tx_byte` is meaningful |
| tx_ready | input | 1 | Radio transmit register can take a byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the pad byte is taken |

## Verification
Two things can fall in the same cycle. The first is a start request arriving while a frame is still being sent. The second is payload forwarding stalling on a missing input byte at the same time as the radio withholds `tx_ready`. The bench injects start pulses with a different length and group a few cycles into frames. It also draws both `tx_ready` and the payload arrival gaps at random. Each frame is judged byte by byte against a packet and checksum built in the bench, and the bench confirms that `done` lands exactly one cycle after the pad byte, with no early or repeated pulse.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam logic [7:0]  TRAIN_BYTE = 8'hAA;
    localparam logic [7:0]  SYNC_BYTE  = 8'h2D;
    localparam logic [7:0]  PAD_BYTE   = 8'hAA;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'hA001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TRAIN,
        ST_SYNC,
        ST_GROUP,
        ST_HDR,
        ST_LEN,
        ST_PAY,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_PAD
    } fr_state_e;

    typedef struct packed {
        logic [7:0] group;
        logic [7:0] header;
        logic [7:0] len;
    } fr_ctx_t;

    // Reflected CRC-16 update for one byte, shift-right form.
    function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] r;
        r = cur ^ {8'h00, din};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic covers_crc(input fr_state_e s);
        return (s == ST_GROUP) || (s == ST_HDR) || (s == ST_LEN) || (s == ST_PAY);
    endfunction

endpackage

// File: rtl/framer_seq.sv
module framer_seq
    import framer_pkg::*;
#(
    parameter int unsigned TRAIN_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] frame_len,
    input  logic [7:0] group_id,
    input  logic [7:0] header_byte,
    input  logic       tx_fire,
    output fr_state_e  state,
    output fr_ctx_t    ctx,
    output logic       launch,
    output logic       done
);

    localparam int unsigned TC_W = (TRAIN_LEN > 1) ? $clog2(TRAIN_LEN) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TRAIN_LEN - 1);

    logic [TC_W-1:0] train_cnt;
    logic [7:0]      remain;

    assign launch = (state == ST_IDLE) && start && (frame_len != 8'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx       <= '0;
            train_cnt <= '0;
            remain    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                state     <= ST_TRAIN;
                ctx       <= '{group: group_id, header: header_byte, len: frame_len};
                train_cnt <= '0;
            end else if (tx_fire) begin
                unique case (state)
                    ST_TRAIN: begin
                        if (train_cnt == TC_LAST) begin
                            state     <= ST_SYNC;
                            train_cnt <= '0;
                        end else begin
                            train_cnt <= train_cnt + 1'b1;
                        end
                    end
                    ST_SYNC:   state <= ST_GROUP;
                    ST_GROUP:  state <= ST_HDR;
                    ST_HDR:    state <= ST_LEN;
                    ST_LEN: begin
                        state  <= ST_PAY;
                        remain <= ctx.len;
                    end
                    ST_PAY: begin
                        remain <= remain - 8'd1;
                        if (remain == 8'd1) state <= ST_CRC_LO;
                    end
                    ST_CRC_LO: state <= ST_CRC_HI;
                    ST_CRC_HI: state <= ST_PAD;
                    ST_PAD: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7: zero-length request leaves the block idle
    assert_zero_len_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && frame_len == 8'd0) |=> (state == ST_IDLE));

    // R9: a start seen while a frame runs does not touch the latched context
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> $stable(ctx));

    // R8: done is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done follows an accepted pad byte
    assert_done_after_pad_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD && tx_fire) |=> (done && state == ST_IDLE));

endmodule

// File: rtl/framer_crc.sv
module framer_crc
    import framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= CRC_SEED;
        end else if (init) begin
            crc <= CRC_SEED;
        end else if (upd) begin
            crc <= crc_step(crc, din);
        end
    end

    // R4: every frame starts from the all-ones seed
    assert_crc_seed_R4: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc == CRC_SEED));

    // R4: bytes outside the covered fields leave the checksum alone
    assert_crc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!init && !upd) |=> $stable(crc));

endmodule

// File: rtl/framer_mux.sv
module framer_mux
    import framer_pkg::*;
(
    input  fr_state_e   state,
    input  fr_ctx_t     ctx,
    input  logic [15:0] crc,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_byte,
    output logic        tx_valid,
    output logic        in_ready
);

    always_comb begin
        tx_byte  = 8'h00;
        tx_valid = 1'b1;
        in_ready = 1'b0;
        unique case (state)
            ST_IDLE:   tx_valid = 1'b0;
            ST_TRAIN:  tx_byte  = TRAIN_BYTE;
            ST_SYNC:   tx_byte  = SYNC_BYTE;
            ST_GROUP:  tx_byte  = ctx.group;
            ST_HDR:    tx_byte  = ctx.header;
            ST_LEN:    tx_byte  = ctx.len;
            ST_PAY: begin
                tx_byte  = in_data;
                tx_valid = in_valid;
                in_ready = tx_ready;
            end
            ST_CRC_LO: tx_byte  = crc[7:0];
            ST_CRC_HI: tx_byte  = crc[15:8];
            ST_PAD:    tx_byte  = PAD_BYTE;
            default:   tx_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/radio_framer.sv
module radio_framer
    import framer_pkg::*;
#(
    parameter int unsigned TRAIN_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] frame_len,
    input  logic [7:0] group_id,
    input  logic [7:0] header_byte,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] tx_byte,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       busy,
    output logic       done
);

    fr_state_e   state;
    fr_ctx_t     ctx;
    logic        launch;
    logic        tx_fire;
    logic [15:0] crc;

    assign tx_fire = tx_valid && tx_ready;
    assign busy    = (state != ST_IDLE);

    framer_seq #(.TRAIN_LEN(TRAIN_LEN)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .frame_len   (frame_len),
        .group_id    (group_id),
        .header_byte (header_byte),
        .tx_fire     (tx_fire),
        .state       (state),
        .ctx         (ctx),
        .launch      (launch),
        .done        (done)
    );

    framer_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (launch),
        .upd  (tx_fire && covers_crc(state)),
        .din  (tx_byte),
        .crc  (crc)
    );

    framer_mux u_mux (
        .state    (state),
        .ctx      (ctx),
        .crc      (crc),
        .in_data  (in_data),
        .in_valid (in_valid),
        .tx_ready (tx_ready),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .in_ready (in_ready)
    );

    // R3: a withheld ready freezes the offered byte outside the payload pass-through
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && state != ST_PAY) |=> (tx_valid && $stable(tx_byte)));

    // R10: payload is consumed only when the radio can take it
    assert_in_ready_gated_R10: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (tx_ready && busy));

    // R8: busy has dropped when done pulses
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/tb_radio_framer.sv
`timescale 1ns/1ps
module tb_radio_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] frame_len = 8'd0;
    logic [7:0] group_id = 8'd0;
    logic [7:0] header_byte = 8'd0;
    logic [7:0] in_data = 8'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;

    logic [7:0] pay [0:255];
    logic [7:0] expb [0:265];
    int exp_len   = 0;
    int exp_total = 0;
    int rdy_pct   = 100;
    int val_pct   = 100;
    int frames_seen = 0;

    // monitor state (written only by the monitor process)
    int   pidx = 0;
    int   bidx = 0;
    bit   take = 1'b0;
    bit   done_due = 1'b0;
    bit   prev_stall = 1'b0;
    logic [7:0] prev_byte = 8'd0;

    always #5 clk = ~clk;

    radio_framer dut (
        .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
        .group_id(group_id), .header_byte(header_byte),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Bit-serial reflected CRC-16, one input bit at a time.
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int b = 0; b < 8; b++) begin
            fb = r[0] ^ d[b];
            r  = r >> 1;
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic string tag_of(input int idx, input int n);
        if (idx < 7 + n)      return "R2 frame byte";
        else if (idx < 9 + n) return "R4 R5 checksum byte";
        else                  return "R6 pad byte";
    endfunction

    // Stimulus for tx_ready and payload, plus monitoring, all at the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            tx_ready = (($urandom % 100) < rdy_pct);
            if (take) begin
                pidx++;
                in_valid = 1'b0;
            end
            if (busy && !in_valid && pidx < exp_len && (($urandom % 100) < val_pct)) begin
                in_valid = 1'b1;
                in_data  = pay[pidx];
            end
        end
        #1;
        if (!rst) begin
            if (done_due) begin
                chk(done && !busy, "R8 done after pad", {done, busy}, 2'b10);
                done_due = 1'b0;
                frames_seen++;
            end else if (done) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end
            if (prev_stall)
                chk(tx_valid && tx_byte == prev_byte, "R3 stall hold", tx_byte, prev_byte);
            if (in_ready)
                chk(tx_ready, "R10 in_ready gated", tx_ready, 1);
            if (busy && bidx >= 7 && bidx < 7 + exp_len && !in_valid)
                chk(!tx_valid, "R10 payload gap", tx_valid, 0);
            if (tx_valid && tx_ready) begin
                chk(bidx < exp_total && tx_byte == expb[bidx], tag_of(bidx, exp_len),
                    tx_byte, (bidx < exp_total) ? expb[bidx] : 8'hxx);
                bidx++;
                if (bidx == exp_total) done_due = 1'b1;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_byte  = tx_byte;
            take = in_valid && in_ready;
            if (start && !busy && frame_len != 8'd0) begin
                pidx = 0;
                bidx = 0;
                take = 1'b0;
                in_valid = 1'b0;
            end
        end
    end

    task automatic send_frame(input int n, input logic [7:0] g, input logic [7:0] h,
                              input int rp, input int vp, input bit poke);
        logic [15:0] c;
        int seen0;
        int wd;
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
        c = 16'hFFFF;
        expb[0] = 8'hAA; expb[1] = 8'hAA; expb[2] = 8'hAA; expb[3] = 8'h2D;
        expb[4] = g; expb[5] = h; expb[6] = 8'(n);
        c = ref_crc(c, g); c = ref_crc(c, h); c = ref_crc(c, 8'(n));
        for (int i = 0; i < n; i++) begin
            expb[7 + i] = pay[i];
            c = ref_crc(c, pay[i]);
        end
        expb[7 + n] = c[7:0];
        expb[8 + n] = c[15:8];
        expb[9 + n] = 8'hAA;
        exp_len   = n;
        exp_total = n + 10;
        rdy_pct   = rp;
        val_pct   = vp;
        seen0     = frames_seen;
        @(negedge clk);
        start = 1'b1; frame_len = 8'(n); group_id = g; header_byte = h;
        @(negedge clk);
        start = 1'b0;
        #2 chk(busy, "R2 busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; frame_len = 8'(n) ^ 8'h05; group_id = ~g; header_byte = ~h;
            @(negedge clk);
            start = 1'b0;  // R9: frame must still match the first request
        end
        wd = 0;
        while (frames_seen == seen0 && wd < 6000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 6000) chk(1'b0, "R8 watchdog frame end", wd, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int s;
        s = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !done && !tx_valid && !in_ready, "R1 reset state",
            {busy, done, tx_valid, in_ready}, 0);
        @(negedge clk);
        rst = 1'b0;

        // Directed: zero length request is dropped (R7)
        @(negedge clk);
        start = 1'b1; frame_len = 8'd0; group_id = 8'hD4; header_byte = 8'h11;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #2 chk(!busy && !tx_valid && !done, "R7 zero length idle",
                   {busy, tx_valid, done}, 0);
            @(negedge clk);
        end

        // Directed corner cases
        send_frame(1,   8'hD4, 8'h11, 100, 100, 1'b0);
        send_frame(4,   8'h00, 8'hFF, 100, 100, 1'b1);
        send_frame(255, 8'h5A, 8'h3C, 100, 100, 1'b0);
        send_frame(2,   8'hFF, 8'h00, 20,  30,  1'b1);

        // Random frames with random stalls
        for (int f = 0; f < 24; f++) begin
            send_frame(1 + ($urandom % 40), 8'($urandom), 8'($urandom),
                       25 + ($urandom % 76), 25 + ($urandom % 76), (f % 3) == 0);
        end

        // R7 again after activity: still idle, nothing sent
        @(negedge clk);
        start = 1'b1; frame_len = 8'd0;
        @(negedge clk);
        start = 1'b0;
        #2 chk(!busy && !tx_valid, "R7 zero length after frames", {busy, tx_valid}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        fails++;
        checks++;
        $display("FAIL R8 global watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule